// File: doc/BRIEF.md
# ATM Transmit HEC Insertion Stage

This stage sits in the transmit path of a cell interface and handles a byte-wide stream of 53-octet ATM cells. Each byte enters with a start-of-cell flag and a cell-type code over a valid/ready handshake. The stage accumulates a CRC-8 over the four header octets. In the fifth octet slot it can then put the finished header error control byte in place of the incoming octet. Coset addition and a test corruption of that byte can be selected.

Before the fifth octet of a user cell is replaced, the stage compares it against an expected integrity pattern. A pattern written by an upstream receiver should survive the path to this point. A mismatch latches a status flag, which is cleared by reading it and which can raise an interrupt. An eight-bit control word selects the options and returns the status. A one-cycle pulse marks each cell that has fully left the stage.

Top module: `cell_hec_stage`

## Requirements
- R1: The HEC is a CRC-8 with generator x^8+x^2+x+1 (0x07), starting from zero, taken most-significant bit first over octets 1 to 4. With insertion enabled it replaces octet 5 (byte index 4).
- R2: Control bit 6 set XORs 0x55 into the HEC before insertion. When the bit is clear the plain CRC is inserted.
- R3: For user (type 0) and OAM (type 1) cells, control bit 5 enables insertion. When the bit is clear, octet 5 is forwarded unchanged.
- R4: For idle cells (type 2), control bit 1 alone enables insertion, independent of bit 5.
- R5: While input `hec_corrupt` is high, an inserted HEC has bit 0 inverted. The input has no effect on a forwarded octet 5.
- R6: Octet 5 of each user cell is compared with 0x55 when control bit 4 is set, or with 0xAA when it is clear. A mismatch sets status bit 0. OAM and idle cells are never checked.
- R7: A read strobe clears status bit 0 at the following edge and returns its old value. A new mismatch in the same cycle as the read wins, so the bit stays set.
- R8: `irq` is high exactly while status bit 0 and the interrupt enable (control bit 2) are both set.
- R9: After reset the control word reads 0xF2 and no output is valid.
- R10: `cell_sent` pulses high for one cycle, one cycle after the 53rd octet of a cell is taken downstream.
- R11: All octets other than octet 5 leave unchanged and in order, and `out_sop` marks octet 1. Under back-pressure the output byte holds stable, and `in_ready` is high when the output register is empty or being drained.
- R12: A write loads control bits 7 to 1 from the write data. Bit 0 cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Stage can take a byte |
| in_data | input | 8 | Input cell byte |
| in_sop | input | 1 | Byte is octet 1 of a cell |
| in_kind | input | 2 | Cell type on octet 1: 0 user, 1 OAM, 2 idle |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Output cell byte |
| out_sop | output | 1 | Output byte is octet 1 |
| cell_sent | output | 1 | One-cycle pulse per completed cell |
| hec_corrupt | input | 1 | Test: invert bit 0 of inserted HEC |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_rd | input | 1 | Control word read strobe (clears status) |
| cfg_wdata | input | 8 | Control write data |
| cfg_rdata | output | 8 | Control word and status |
| irq | output | 1 | Integrity-error interrupt |

## Verification
Two events can land on the same clock edge. One is the integrity mismatch that sets the status flag as octet 5 of a user cell is accepted. The other is the read strobe that clears the flag. The bench raises the read strobe in exactly the cycle where a mismatching octet 5 is taken. It expects the read to return the old clear value and the flag to still be set afterwards. A second pair of reads confirms that the clear then works normally.

// File: rtl/hec_pkg.sv
package hec_pkg;
  typedef enum logic [1:0] {KIND_USER = 2'd0, KIND_OAM = 2'd1, KIND_IDLE = 2'd2} cell_kind_e;

  localparam logic [7:0] HEC_POLY  = 8'h07;
  localparam logic [7:0] HEC_COSET = 8'h55;
  localparam logic [7:0] PAT_HI    = 8'h55;
  localparam logic [7:0] PAT_LO    = 8'hAA;

  // control word bit positions
  localparam int CB_SCRAM  = 7;
  localparam int CB_COSET  = 6;
  localparam int CB_INS    = 5;
  localparam int CB_PAT    = 4;
  localparam int CB_GFC    = 3;
  localparam int CB_IE     = 2;
  localparam int CB_IDLE   = 1;
  localparam int CB_STAT   = 0;
  localparam logic [7:0] CTRL_RST = 8'hF2;

  // one byte of CRC-8, MSB first
  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] d);
    logic [7:0] c;
    c = crc ^ d;
    for (int i = 0; i < 8; i++) c = c[7] ? ((c << 1) ^ HEC_POLY) : (c << 1);
    return c;
  endfunction

  function automatic logic [7:0] hec_finish(input logic [7:0] crc, input logic coset_en,
                                           input logic corrupt);
    return crc ^ (coset_en ? HEC_COSET : 8'h00) ^ {7'd0, corrupt};
  endfunction
endpackage

// File: rtl/cell_pos_tracker.sv
module cell_pos_tracker
  import hec_pkg::*;
#(
  parameter int CELL_LEN = 53,
  localparam int PW = $clog2(CELL_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          sop,
  input  cell_kind_e    kind,
  output logic [PW-1:0] pos,
  output cell_kind_e    cur_kind,
  output logic          is_last
);
  logic [PW-1:0] cnt_q;
  cell_kind_e    kind_q;

  assign pos      = sop ? '0 : cnt_q;
  assign cur_kind = sop ? kind : kind_q;
  assign is_last  = (pos == PW'(CELL_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      kind_q <= KIND_USER;
    end else if (acc) begin
      cnt_q  <= is_last ? '0 : pos + 1'b1;
      kind_q <= cur_kind;
    end
  end
endmodule

// File: rtl/hec_crc_acc.sv
module hec_crc_acc
  import hec_pkg::*;
#(
  parameter int HDR_LEN = 4,
  parameter int PW      = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [PW-1:0] pos,
  input  logic [7:0]    data,
  output logic [7:0]    crc
);
  logic [7:0] crc_q;
  logic       in_hdr;

  assign in_hdr = (pos < PW'(HDR_LEN));
  assign crc    = crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else if (acc && in_hdr) crc_q <= crc8_step((pos == '0) ? 8'h00 : crc_q, data);
  end
endmodule

// File: rtl/hec_ctrl_regs.sv
module hec_ctrl_regs
  import hec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] wdata,
  input  logic       err_set,
  output logic [7:0] ctrl,
  output logic       irq
);
  logic [7:1] cfg_q;
  logic       stat_q;
  logic       unused_wbit;

  assign unused_wbit = wdata[0];
  assign ctrl        = {cfg_q, stat_q};
  assign irq         = stat_q & cfg_q[CB_IE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CTRL_RST[7:1];
      stat_q <= CTRL_RST[0];
    end else begin
      if (wr) cfg_q <= wdata[7:1];
      if (err_set) stat_q <= 1'b1;
      else if (rd) stat_q <= 1'b0;
    end
  end

  p_status_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> stat_q);
  p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !err_set |=> !stat_q);
  p_wr_keeps_stat_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr && !rd && !err_set |=> stat_q == $past(stat_q));
endmodule

// File: rtl/cell_hec_stage.sv
module cell_hec_stage
  import hec_pkg::*;
#(
  parameter int CELL_LEN = 53,
  parameter int HDR_LEN  = 4,
  localparam int PW = $clog2(CELL_LEN)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sop,
  input  logic [1:0] in_kind,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_sop,
  output logic       cell_sent,
  input  logic       hec_corrupt,
  input  logic       cfg_wr,
  input  logic       cfg_rd,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  output logic       irq
);
  logic          acc, at_slot, ins_on, ins_evt, pass_evt, dp_err, is_last, out_last;
  logic [PW-1:0] pos;
  cell_kind_e    cur_kind;
  logic [7:0]    crc, hec_val, exp_pat, byte_out, ctrl;

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;

  cell_pos_tracker #(.CELL_LEN(CELL_LEN)) u_pos (
    .clk, .rst_n, .acc, .sop(in_sop), .kind(cell_kind_e'(in_kind)),
    .pos, .cur_kind, .is_last
  );

  hec_crc_acc #(.HDR_LEN(HDR_LEN), .PW(PW)) u_crc (
    .clk, .rst_n, .acc, .pos, .data(in_data), .crc
  );

  hec_ctrl_regs u_regs (
    .clk, .rst_n, .wr(cfg_wr), .rd(cfg_rd), .wdata(cfg_wdata),
    .err_set(dp_err), .ctrl, .irq
  );

  assign cfg_rdata = ctrl;
  assign at_slot   = (pos == PW'(HDR_LEN));
  assign ins_on    = (cur_kind == KIND_IDLE) ? ctrl[CB_IDLE] : ctrl[CB_INS];
  assign hec_val   = hec_finish(crc, ctrl[CB_COSET], hec_corrupt);
  assign ins_evt   = acc && at_slot && ins_on;
  assign pass_evt  = acc && at_slot && !ins_on;
  assign exp_pat   = ctrl[CB_PAT] ? PAT_HI : PAT_LO;
  assign dp_err    = acc && at_slot && (cur_kind == KIND_USER) && (in_data != exp_pat);
  assign byte_out  = ins_evt ? hec_val : in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sop   <= 1'b0;
      out_last  <= 1'b0;
      cell_sent <= 1'b0;
    end else begin
      if (acc) begin
        out_valid <= 1'b1;
        out_data  <= byte_out;
        out_sop   <= (pos == '0);
        out_last  <= is_last;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      cell_sent <= out_valid && out_ready && out_last;
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop));
  p_hec_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ins_evt |=> out_data == $past(hec_val));
  p_pass_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pass_evt |=> out_data == $past(in_data));
  p_pulse_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cell_sent |=> !cell_sent);
endmodule

// File: tb/cell_hec_stage_tb.sv
`timescale 1ns/100ps
module cell_hec_stage_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_sop = 1'b0, out_ready = 1'b1, hec_corrupt = 1'b0;
  logic       cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [7:0] in_data = '0, cfg_wdata = '0;
  logic [1:0] in_kind = '0;
  logic       in_ready, out_valid, out_sop, cell_sent, irq;
  logic [7:0] out_data, cfg_rdata;

  int checks = 0, fails = 0;
  logic [7:0] in_b [0:52];
  logic [7:0] cap  [0:52];
  logic       cap_sop [0:52];
  int         pulses, pulse_cyc, last_cyc;
  logic [7:0] rd_val;

  always #2.5 clk = ~clk;

  cell_hec_stage u_dut (
    .clk, .rst_n, .in_valid, .in_ready, .in_data, .in_sop, .in_kind,
    .out_valid, .out_ready, .out_data, .out_sop, .cell_sent, .hec_corrupt,
    .cfg_wr, .cfg_rd, .cfg_wdata, .cfg_rdata, .irq
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // serial-bit CRC model
  function automatic logic [7:0] ref_hec(input logic [31:0] hdr, input bit coset, input bit inj);
    logic [7:0] r = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      logic fb = r[7] ^ hdr[i];
      r = {r[6:0], 1'b0} ^ (fb ? 8'b0000_0111 : 8'b0);
    end
    if (coset) r = r ^ 8'b0101_0101;
    if (inj) r[0] = ~r[0];
    return r;
  endfunction

  task automatic cfg_write(input logic [7:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(output logic [7:0] v);
    @(negedge clk); cfg_rd = 1'b1; #1 v = cfg_rdata;
    @(negedge clk); cfg_rd = 1'b0;
  endtask

  task automatic send_cell(input logic [1:0] kind, input logic [31:0] hdr, input logic [7:0] oct5,
                           input bit bp, input bit rd_at5);
    int sent = 0, cap_n = 0, cyc = 0;
    pulses = 0; pulse_cyc = -1; last_cyc = -10;
    for (int i = 0; i < 53; i++)
      in_b[i] = (i < 4) ? hdr[31-8*i -: 8] : (i == 4) ? oct5 : 8'(i * 7 + 3);
    while (cap_n < 53 || cyc <= last_cyc + 2) begin
      @(negedge clk);
      if (cell_sent) begin pulses++; pulse_cyc = cyc; end
      out_ready = !(bp && (cyc % 3 == 1));
      in_valid  = (sent < 53);
      in_data   = (sent < 53) ? in_b[sent] : 8'h00;
      in_sop    = (sent == 0);
      in_kind   = kind;
      cfg_rd    = rd_at5 && (sent == 4);
      #1;
      if (cfg_rd) rd_val = cfg_rdata;
      if (out_valid && out_ready && cap_n < 53) begin
        cap[cap_n] = out_data; cap_sop[cap_n] = out_sop;
        if (cap_n == 52) last_cyc = cyc;
        cap_n++;
      end
      if (in_valid && in_ready) sent++;
      cyc++;
    end
    in_valid = 1'b0; in_sop = 1'b0; cfg_rd = 1'b0; out_ready = 1'b1;
  endtask

  // check the captured cell against the inputs with an expected octet 5
  task automatic check_cell(input logic [7:0] exp5, input string req);
    int bad = 0;
    chk(cap[4] == exp5, req, "octet 5", cap[4], exp5);
    for (int i = 0; i < 53; i++)
      if (i != 4 && (cap[i] != in_b[i] || cap_sop[i] != (i == 0))) bad++;
    chk(bad == 0, "R11", "other octets / sop mismatches", bad, 0);
    chk(pulses == 1 && pulse_cyc == last_cyc + 1, "R10", "cell_sent pulse cycle",
        pulse_cyc - last_cyc, 1);
  endtask

  task automatic t_reset();
    #1;
    chk(cfg_rdata == 8'hF2, "R9", "reset control word", cfg_rdata, 8'hF2);
    chk(!out_valid && !cell_sent && !irq, "R9", "reset outputs", {out_valid, cell_sent, irq}, 0);
  endtask

  task automatic t_user_insert();
    send_cell(2'd0, 32'h12345678, 8'h55, 0, 0);
    check_cell(ref_hec(32'h12345678, 1, 0), "R1");
    chk(cfg_rdata[0] == 1'b0, "R6", "matching pattern no status", cfg_rdata[0], 0);
  endtask

  task automatic t_coset_off();
    cfg_write(8'hB2);
    send_cell(2'd0, 32'h0A0B0C0D, 8'h55, 0, 0);
    check_cell(ref_hec(32'h0A0B0C0D, 0, 0), "R2");
    cfg_write(8'hF2);
  endtask

  task automatic t_ins_off();
    cfg_write(8'hD2);
    send_cell(2'd0, 32'h11223344, 8'h55, 0, 0);
    check_cell(8'h55, "R3");
    send_cell(2'd1, 32'h00000005, 8'h13, 0, 0);
    check_cell(8'h13, "R3");
    chk(cfg_rdata[0] == 1'b0, "R6", "OAM not checked", cfg_rdata[0], 0);
  endtask

  task automatic t_idle();
    cfg_write(8'hD2); // user insertion off, idle on
    send_cell(2'd2, 32'h00000001, 8'h6A, 0, 0);
    check_cell(8'h52, "R4");
    cfg_write(8'hF0); // user on, idle off
    send_cell(2'd2, 32'h00000001, 8'h6A, 0, 0);
    check_cell(8'h6A, "R4");
    chk(cfg_rdata[0] == 1'b0, "R6", "idle not checked", cfg_rdata[0], 0);
    send_cell(2'd0, 32'h00000001, 8'h55, 0, 0);
    check_cell(8'h52, "R4");
    cfg_write(8'hF2);
  endtask

  task automatic t_inject();
    hec_corrupt = 1'b1;
    send_cell(2'd0, 32'hCAFE0042, 8'h55, 0, 0);
    check_cell(ref_hec(32'hCAFE0042, 1, 1), "R5");
    cfg_write(8'hD2);
    send_cell(2'd0, 32'hCAFE0042, 8'h55, 0, 0);
    check_cell(8'h55, "R5");
    hec_corrupt = 1'b0;
    cfg_write(8'hF2);
  endtask

  task automatic t_integrity();
    logic [7:0] v;
    send_cell(2'd0, 32'h01020304, 8'hAA, 0, 0);
    check_cell(ref_hec(32'h01020304, 1, 0), "R6");
    chk(cfg_rdata[0] == 1'b1, "R6", "mismatch vs 0x55 sets status", cfg_rdata[0], 1);
    chk(irq == 1'b0, "R8", "irq masked", irq, 0);
    cfg_read(v);
    chk(v[0] == 1'b1, "R7", "read returns set status", v[0], 1);
    cfg_read(v);
    chk(v[0] == 1'b0, "R7", "status cleared by read", v[0], 0);
    cfg_write(8'hE2); // pattern 0xAA
    send_cell(2'd0, 32'h01020304, 8'hAA, 0, 0);
    chk(cfg_rdata[0] == 1'b0, "R6", "0xAA matches when bit4 clear", cfg_rdata[0], 0);
    send_cell(2'd0, 32'h01020304, 8'h55, 0, 0);
    chk(cfg_rdata[0] == 1'b1, "R6", "0x55 mismatches when bit4 clear", cfg_rdata[0], 1);
    cfg_read(v);
    cfg_write(8'hF2);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    cfg_write(8'hF6);
    send_cell(2'd0, 32'h0, 8'h00, 0, 0);
    #1;
    chk(irq == 1'b1, "R8", "irq with enable and status", irq, 1);
    cfg_read(v);
    #1;
    chk(irq == 1'b0, "R8", "irq drops after read", irq, 0);
    cfg_write(8'hF2);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    rd_val = 8'hFF;
    send_cell(2'd0, 32'h0000FFFF, 8'h77, 0, 1);
    chk(rd_val[0] == 1'b0, "R7", "same-cycle read returns old status", rd_val[0], 0);
    chk(cfg_rdata[0] == 1'b1, "R7", "set wins over read", cfg_rdata[0], 1);
    cfg_read(v);
    cfg_read(v);
    chk(v[0] == 1'b0, "R7", "cleared after later read", v[0], 0);
  endtask

  task automatic t_backpressure();
    send_cell(2'd0, 32'h9ABCDEF0, 8'h55, 1, 0);
    check_cell(ref_hec(32'h9ABCDEF0, 1, 0), "R11");
  endtask

  task automatic t_write_bit0();
    cfg_write(8'h2B);
    #1;
    chk(cfg_rdata == 8'h2A, "R12", "bit0 not writable", cfg_rdata, 8'h2A);
    cfg_write(8'hF2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_user_insert();
    t_coset_off();
    t_ins_off();
    t_idle();
    t_inject();
    t_integrity();
    t_irq();
    t_collide();
    t_backpressure();
    t_write_bit0();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule